// File: doc/BRIEF.md
# Codec Response Ring Writer

This block takes replies coming back from audio codecs and stores them where host software can read them. Each reply is a 32-bit response word plus the address of the codec that sent it and a flag that marks the reply as unsolicited. In normal operation the reply goes into a 256-slot circular ring in system memory. Each slot is 8 bytes, written as two 32-bit beats on a simple write port that uses a valid/acknowledge handshake. The block keeps the ring's write pointer and counts the replies it has stored. It raises a response interrupt status bit when the count reaches a programmed threshold, or when the command side reports that its ring has drained.

Software can also issue one command at a time outside the ring. In that case it sets a busy flag, and the next reply goes into an immediate response register and is not written to the ring. When software acknowledges the interrupt status bit, the reply count is cleared and a one-cycle pulse is sent to the command fetcher so that it resumes work. Configuration arrives on a small register write port: a select code chooses the register and a data word carries the value.

Top module: `rsp_ring_writer`

## Requirements
- R1: After reset, the write pointer is 0, the interrupt status, immediate busy and immediate valid are all 0, no memory beat is pending, and rspReady is 1.
- R2: For each stored reply, the pointer first advances by one modulo 256. The slot address is base + 8 × new pointer. The response word goes first at that address, then the extended word at address + 4.
- R3: In the extended word, bits 3:0 carry the codec address and bit 4 is 1 for an unsolicited reply. All other bits are 0.
- R4: The ring base is written with select 0. The low 7 bits of the written value are ignored, so the base is always 128-byte aligned.
- R5: When immediate busy (select 5, bit 0) is set, the next reply is stored in immResp instead of the ring. In the same step busy clears, valid sets and immCodec takes the codec address. The pointer does not move and no memory beat is issued.
- R6: The control register is written with select 3. Bit 0 enables ring DMA, bit 1 enables the interrupt and bit 2 enables the overrun interrupt. All three bits read back on ringCtl. With bit 0 clear, ring replies are dropped: no beat is issued and the pointer does not move.
- R7: After each ring entry completes, the count increments. The status bit sets if the count equals the threshold (select 2, 8 bits) or cmdRingEmpty is high, provided control bit 1 is set.
- R8: With control bit 1 clear, the status bit never sets, however many replies are stored.
- R9: The status register is written with select 4. Writing 1 to bit 0 clears the status bit, resets the count to 0, and pulses fetchRetrigger high for exactly one cycle. Writing 0 there has no effect.
- R10: A write with select 1 whose bit 15 is 1 resets the pointer to 0. A write with select 1 whose bit 15 is 0 leaves the pointer unchanged.
- R11: A reply waits in a one-deep holding register. rspReady stays low while a reply is held. A memory beat keeps its address and data stable until memWrAck is seen.
- R12: A write with select 5 loads busy from bit 0, and writing 1 to bit 1 clears valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rspValid | input | 1 | Codec reply offered |
| rspReady | output | 1 | Holding register is free |
| rspData | input | 32 | Reply word |
| rspUnsol | input | 1 | Reply is unsolicited |
| rspCodec | input | 4 | Address of the replying codec |
| cfgWe | input | 1 | Register write strobe |
| cfgSel | input | 3 | Register select code |
| cfgWdata | input | 32 | Register write data |
| cmdRingEmpty | input | 1 | Command ring has drained |
| fetchRetrigger | output | 1 | One-cycle pulse that restarts command fetch |
| memWrValid | output | 1 | Memory write beat pending |
| memWrAck | input | 1 | Memory accepts the beat |
| memWrAddr | output | 32 | Byte address of the beat |
| memWrData | output | 32 | Data of the beat |
| ringWp | output | 8 | Ring write pointer |
| ringCtl | output | 3 | Control bits (DMA, interrupt, overrun interrupt enable) |
| rspIntSts | output | 1 | Response interrupt status |
| immResp | output | 32 | Immediate response register |
| immBusy | output | 1 | Immediate command busy |
| immValid | output | 1 | Immediate response valid |
| immCodec | output | 4 | Codec address of the immediate response |

## Verification
A wrong pointer shows on ringWp after a single reply, and on memWrAddr at the next entry's first beat, about two cycles after the reply is accepted. A count that is off by one delays or advances rspIntSts by a whole reply, so the bench steps through threshold hits and drained-ring hits with a model of the count in mind. A wrong word order or a wrong extended-word layout shows on the very first two beats. A fault in the hold or route decision shows at once as a lost or duplicated beat, or as an immResp that fails to update.

// File: rtl/rrw_pkg.sv
package rrw_pkg;
  localparam logic [2:0] SEL_BASE   = 3'd0;
  localparam logic [2:0] SEL_WP     = 3'd1;
  localparam logic [2:0] SEL_THRESH = 3'd2;
  localparam logic [2:0] SEL_CTL    = 3'd3;
  localparam logic [2:0] SEL_STS    = 3'd4;
  localparam logic [2:0] SEL_IMM    = 3'd5;

  localparam int CTL_W      = 3;
  localparam int CTL_DMA    = 0;
  localparam int CTL_INT    = 1;
  localparam int STS_IRQ    = 0;
  localparam int WP_RST_BIT = 15;
  localparam int IMM_BUSY   = 0;
  localparam int IMM_VALID  = 1;

  typedef struct packed {
    logic ptrAdvance;
    logic ptrClear;
    logic baseLoad;
    logic secondWord;
  } dp_strobe_t;
endpackage

// File: rtl/rrw_datapath.sv
module rrw_datapath
  import rrw_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int RSP_W      = 32,
  parameter int PTR_W      = 8,
  parameter int CODEC_W    = 4,
  parameter int ALIGN_BITS = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  dp_strobe_t         strobe,
  input  logic [ADDR_W-1:0]  cfgWdata,
  input  logic [RSP_W-1:0]   holdData,
  input  logic               holdUnsol,
  input  logic [CODEC_W-1:0] holdCodec,
  output logic [PTR_W-1:0]   ringWp,
  output logic [ADDR_W-1:0]  memWrAddr,
  output logic [RSP_W-1:0]   memWrData
);
  localparam int ENTRY_SHIFT = 3;
  localparam int PAD_W       = ADDR_W - PTR_W - ENTRY_SHIFT;
  localparam int EXT_PAD     = RSP_W - CODEC_W - 1;

  logic [PTR_W-1:0]  wp;
  logic [PTR_W-1:0]  wpNext;
  logic [ADDR_W-1:0] baseReg;
  logic [ADDR_W-1:0] entryAddr;
  logic [ADDR_W-1:0] slotOffset;
  logic [RSP_W-1:0]  extWord;
  logic              unusedLow;

  assign unusedLow  = ^cfgWdata[ALIGN_BITS-1:0];
  assign wpNext     = wp + PTR_W'(1);
  assign slotOffset = {{PAD_W{1'b0}}, wpNext, {ENTRY_SHIFT{1'b0}}};
  assign extWord    = {{EXT_PAD{1'b0}}, holdUnsol, holdCodec};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp        <= '0;
      baseReg   <= '0;
      entryAddr <= '0;
    end else begin
      if (strobe.baseLoad)
        baseReg <= {cfgWdata[ADDR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
      if (strobe.ptrAdvance)
        entryAddr <= baseReg + slotOffset;
      if (strobe.ptrClear)
        wp <= '0;
      else if (strobe.ptrAdvance)
        wp <= wpNext;
    end
  end

  always_comb begin
    if (strobe.secondWord) begin
      memWrAddr = entryAddr + ADDR_W'(4);
      memWrData = extWord;
    end else begin
      memWrAddr = entryAddr;
      memWrData = holdData;
    end
  end

  assign ringWp = wp;

  // R2: the pointer only steps forward by one or returns to zero
  a_r2_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wp != $past(wp)) |-> ((wp == $past(wp) + PTR_W'(1)) || (wp == '0)));
endmodule

// File: rtl/rrw_ctrl.sv
module rrw_ctrl
  import rrw_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int RSP_W   = 32,
  parameter int CODEC_W = 4,
  parameter int CNT_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rspValid,
  output logic               rspReady,
  input  logic [RSP_W-1:0]   rspData,
  input  logic               rspUnsol,
  input  logic [CODEC_W-1:0] rspCodec,
  input  logic               cfgWe,
  input  logic [2:0]         cfgSel,
  input  logic [ADDR_W-1:0]  cfgWdata,
  input  logic               cmdRingEmpty,
  input  logic               memWrAck,
  output logic               memWrValid,
  output dp_strobe_t         strobe,
  output logic [RSP_W-1:0]   holdData,
  output logic               holdUnsol,
  output logic [CODEC_W-1:0] holdCodec,
  output logic [CTL_W-1:0]   ringCtl,
  output logic               rspIntSts,
  output logic               fetchRetrigger,
  output logic [RSP_W-1:0]   immResp,
  output logic               immBusy,
  output logic               immValid,
  output logic [CODEC_W-1:0] immCodec
);
  typedef enum logic [1:0] {ST_IDLE, ST_WORD0, ST_WORD1} wr_state_e;

  wr_state_e        state, stateNext;
  logic             holdValid;
  logic [CNT_W-1:0] thresh, rspCnt, cntInc;
  logic             startEntry, immTake, dropEntry, entryDone;
  logic             hitIrq, setIrq, stsClr;
  logic             wrCtl, wrThresh, wrImm;
  logic             unusedCfg;

  assign unusedCfg = ^cfgWdata;

  always_comb begin
    startEntry = (state == ST_IDLE) && holdValid && !immBusy && ringCtl[CTL_DMA];
    dropEntry  = (state == ST_IDLE) && holdValid && !immBusy && !ringCtl[CTL_DMA];
    immTake    = (state == ST_IDLE) && holdValid && immBusy;
    entryDone  = (state == ST_WORD1) && memWrAck;
    memWrValid = (state != ST_IDLE);
    rspReady   = !holdValid;

    wrCtl    = cfgWe && (cfgSel == SEL_CTL);
    wrThresh = cfgWe && (cfgSel == SEL_THRESH);
    wrImm    = cfgWe && (cfgSel == SEL_IMM);
    stsClr   = cfgWe && (cfgSel == SEL_STS) && cfgWdata[STS_IRQ];

    cntInc = rspCnt + CNT_W'(1);
    hitIrq = (cntInc == thresh) || cmdRingEmpty;
    setIrq = entryDone && hitIrq && ringCtl[CTL_INT];

    strobe.ptrAdvance = startEntry;
    strobe.ptrClear   = cfgWe && (cfgSel == SEL_WP) && cfgWdata[WP_RST_BIT];
    strobe.baseLoad   = cfgWe && (cfgSel == SEL_BASE);
    strobe.secondWord = (state == ST_WORD1);

    stateNext = state;
    case (state)
      ST_IDLE:  if (startEntry) stateNext = ST_WORD0;
      ST_WORD0: if (memWrAck)   stateNext = ST_WORD1;
      ST_WORD1: if (memWrAck)   stateNext = ST_IDLE;
      default:                  stateNext = ST_IDLE;
    endcase
  end

  // input holding register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      holdValid <= 1'b0;
      holdData  <= '0;
      holdUnsol <= 1'b0;
      holdCodec <= '0;
    end else if (rspValid && rspReady) begin
      holdValid <= 1'b1;
      holdData  <= rspData;
      holdUnsol <= rspUnsol;
      holdCodec <= rspCodec;
    end else if (entryDone || dropEntry || immTake) begin
      holdValid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  // configuration, count and interrupt status
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thresh         <= '0;
      ringCtl        <= '0;
      rspCnt         <= '0;
      rspIntSts      <= 1'b0;
      fetchRetrigger <= 1'b0;
    end else begin
      fetchRetrigger <= 1'b0;
      if (wrThresh) thresh  <= cfgWdata[CNT_W-1:0];
      if (wrCtl)    ringCtl <= cfgWdata[CTL_W-1:0];
      if (entryDone) rspCnt <= cntInc;
      if (setIrq) begin
        rspIntSts <= 1'b1;
      end else if (stsClr && rspIntSts) begin
        rspIntSts      <= 1'b0;
        rspCnt         <= '0;
        fetchRetrigger <= 1'b1;
      end
    end
  end

  // immediate command response path
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      immResp  <= '0;
      immBusy  <= 1'b0;
      immValid <= 1'b0;
      immCodec <= '0;
    end else if (immTake) begin
      immResp  <= holdData;
      immBusy  <= 1'b0;
      immValid <= 1'b1;
      immCodec <= holdCodec;
    end else if (wrImm) begin
      immBusy <= cfgWdata[IMM_BUSY];
      if (cfgWdata[IMM_VALID]) immValid <= 1'b0;
    end
  end

  // R11: the holding register is occupied for the whole memory write
  a_r11_hold_while_writing: assert property (@(posedge clk) disable iff (!rst_n)
    memWrValid |-> !rspReady);

  // R9: the retrigger pulse follows a falling status bit
  a_r9_retrig_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    fetchRetrigger |-> $fell(rspIntSts));

  // R5: a new immediate response drops busy in the same step
  a_r5_imm_handoff: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(immValid) |-> $fell(immBusy));
endmodule

// File: rtl/rsp_ring_writer.sv
module rsp_ring_writer
  import rrw_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int RSP_W      = 32,
  parameter int PTR_W      = 8,
  parameter int CODEC_W    = 4,
  parameter int CNT_W      = 8,
  parameter int ALIGN_BITS = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rspValid,
  output logic               rspReady,
  input  logic [RSP_W-1:0]   rspData,
  input  logic               rspUnsol,
  input  logic [CODEC_W-1:0] rspCodec,
  input  logic               cfgWe,
  input  logic [2:0]         cfgSel,
  input  logic [ADDR_W-1:0]  cfgWdata,
  input  logic               cmdRingEmpty,
  output logic               fetchRetrigger,
  output logic               memWrValid,
  input  logic               memWrAck,
  output logic [ADDR_W-1:0]  memWrAddr,
  output logic [RSP_W-1:0]   memWrData,
  output logic [PTR_W-1:0]   ringWp,
  output logic [CTL_W-1:0]   ringCtl,
  output logic               rspIntSts,
  output logic [RSP_W-1:0]   immResp,
  output logic               immBusy,
  output logic               immValid,
  output logic [CODEC_W-1:0] immCodec
);
  dp_strobe_t         strobe;
  logic [RSP_W-1:0]   holdData;
  logic               holdUnsol;
  logic [CODEC_W-1:0] holdCodec;

  rrw_ctrl #(
    .ADDR_W(ADDR_W), .RSP_W(RSP_W), .CODEC_W(CODEC_W), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .rspValid(rspValid), .rspReady(rspReady), .rspData(rspData),
    .rspUnsol(rspUnsol), .rspCodec(rspCodec),
    .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgWdata(cfgWdata),
    .cmdRingEmpty(cmdRingEmpty), .memWrAck(memWrAck), .memWrValid(memWrValid),
    .strobe(strobe), .holdData(holdData), .holdUnsol(holdUnsol), .holdCodec(holdCodec),
    .ringCtl(ringCtl), .rspIntSts(rspIntSts), .fetchRetrigger(fetchRetrigger),
    .immResp(immResp), .immBusy(immBusy), .immValid(immValid), .immCodec(immCodec)
  );

  rrw_datapath #(
    .ADDR_W(ADDR_W), .RSP_W(RSP_W), .PTR_W(PTR_W), .CODEC_W(CODEC_W),
    .ALIGN_BITS(ALIGN_BITS)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .cfgWdata(cfgWdata),
    .holdData(holdData), .holdUnsol(holdUnsol), .holdCodec(holdCodec),
    .ringWp(ringWp), .memWrAddr(memWrAddr), .memWrData(memWrData)
  );

  // R11: a stalled beat keeps its address and data
  a_r11_beat_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (memWrValid && !memWrAck) |=> (memWrValid && $stable(memWrAddr) && $stable(memWrData)));
endmodule

// File: tb/rsp_ring_writer_test.sv
module rsp_ring_writer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rspValid = 1'b0;
  logic        rspReady;
  logic [31:0] rspData = '0;
  logic        rspUnsol = 1'b0;
  logic [3:0]  rspCodec = '0;
  logic        cfgWe = 1'b0;
  logic [2:0]  cfgSel = '0;
  logic [31:0] cfgWdata = '0;
  logic        cmdRingEmpty = 1'b0;
  logic        fetchRetrigger;
  logic        memWrValid;
  logic        memWrAck = 1'b1;
  logic [31:0] memWrAddr, memWrData;
  logic [7:0]  ringWp;
  logic [2:0]  ringCtl;
  logic        rspIntSts;
  logic [31:0] immResp;
  logic        immBusy, immValid;
  logic [3:0]  immCodec;

  int checks = 0;
  int failures = 0;
  int beatCnt = 0;
  int retrigCnt = 0;
  logic [31:0] beatAddr [0:1023];
  logic [31:0] beatData [0:1023];

  localparam logic [31:0] BASE = 32'h0001_2380;

  // {data[38:7], unsol[6], codec[5:2], cmdEmpty[1], expIrq[0]} with threshold 3
  localparam logic [38:0] VEC [8] = '{
    {32'h1111_0001, 1'b0, 4'h1, 1'b0, 1'b0},
    {32'h2222_0002, 1'b1, 4'h2, 1'b0, 1'b0},
    {32'h3333_0003, 1'b0, 4'hE, 1'b0, 1'b1},
    {32'hA5A5_5A5A, 1'b1, 4'h0, 1'b1, 1'b1},
    {32'h0000_0000, 1'b0, 4'h7, 1'b0, 1'b0},
    {32'hFFFF_FFFF, 1'b1, 4'hF, 1'b0, 1'b0},
    {32'h1234_5678, 1'b0, 4'h3, 1'b1, 1'b1},
    {32'hDEAD_BEEF, 1'b1, 4'hA, 1'b0, 1'b0}
  };

  rsp_ring_writer uut (
    .clk(clk), .rst_n(rst_n), .rspValid(rspValid), .rspReady(rspReady),
    .rspData(rspData), .rspUnsol(rspUnsol), .rspCodec(rspCodec),
    .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgWdata(cfgWdata),
    .cmdRingEmpty(cmdRingEmpty), .fetchRetrigger(fetchRetrigger),
    .memWrValid(memWrValid), .memWrAck(memWrAck), .memWrAddr(memWrAddr),
    .memWrData(memWrData), .ringWp(ringWp), .ringCtl(ringCtl),
    .rspIntSts(rspIntSts), .immResp(immResp), .immBusy(immBusy),
    .immValid(immValid), .immCodec(immCodec)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (memWrValid && memWrAck && beatCnt < 1024) begin
      beatAddr[beatCnt] <= memWrAddr;
      beatData[beatCnt] <= memWrData;
      beatCnt <= beatCnt + 1;
    end
    if (fetchRetrigger) retrigCnt <= retrigCnt + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgSel = sel; cfgWdata = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic sendRsp(input logic [31:0] d, input logic u, input logic [3:0] c);
    @(negedge clk);
    rspValid = 1'b1; rspData = d; rspUnsol = u; rspCodec = c;
    while (!rspReady) @(negedge clk);
    @(negedge clk);
    rspValid = 1'b0;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int bIdx;
    int r0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 wp", 32'(ringWp), 32'd0);
    chk("R1 irq", 32'(rspIntSts), 32'd0);
    chk("R1 busy", 32'(immBusy), 32'd0);
    chk("R1 valid", 32'(immValid), 32'd0);
    chk("R1 memWrValid", 32'(memWrValid), 32'd0);
    chk("R1 ready", 32'(rspReady), 32'd1);

    cfgWrite(3'd0, 32'h0001_23FF);   // R4: low bits must be dropped
    cfgWrite(3'd2, 32'd3);
    cfgWrite(3'd3, 32'd7);
    chk("R6 ctl readback", 32'(ringCtl), 32'd7);
    cfgWrite(3'd3, 32'd3);

    // table-driven ring writes: R2 R3 R4 R7 R9
    bIdx = 0;
    for (int i = 0; i < 8; i++) begin
      cmdRingEmpty = VEC[i][1];
      sendRsp(VEC[i][38:7], VEC[i][6], VEC[i][5:2]);
      settle();
      chk("R2 wp", 32'(ringWp), 32'(i + 1));
      chk("R2 R4 addr0", beatAddr[bIdx], BASE + 32'(8 * (i + 1)));
      chk("R2 data0", beatData[bIdx], VEC[i][38:7]);
      chk("R2 addr1", beatAddr[bIdx + 1], BASE + 32'(8 * (i + 1) + 4));
      chk("R3 ext", beatData[bIdx + 1], {27'd0, VEC[i][6], VEC[i][5:2]});
      chk("R7 irq", 32'(rspIntSts), 32'(VEC[i][0]));
      bIdx += 2;
      cmdRingEmpty = 1'b0;
      if (VEC[i][0]) begin
        r0 = retrigCnt;
        cfgWrite(3'd4, 32'd1);
        repeat (2) @(negedge clk);
        chk("R9 cleared", 32'(rspIntSts), 32'd0);
        chk("R9 retrig", 32'(retrigCnt), 32'(r0 + 1));
      end
    end
    chk("R2 beats", 32'(beatCnt), 32'd16);

    // R6 dropped replies
    cfgWrite(3'd3, 32'd2);
    sendRsp(32'h5555_5555, 1'b0, 4'h1);
    settle();
    chk("R6 wp kept", 32'(ringWp), 32'd8);
    chk("R6 no beat", 32'(beatCnt), 32'd16);
    chk("R6 ready", 32'(rspReady), 32'd1);
    cfgWrite(3'd3, 32'd3);

    // R10 pointer reset
    cfgWrite(3'd1, 32'h0000_00FF);
    chk("R10 no bit15", 32'(ringWp), 32'd8);
    cfgWrite(3'd1, 32'h0000_8000);
    chk("R10 reset", 32'(ringWp), 32'd0);

    // R9 writing zero has no effect
    cmdRingEmpty = 1'b1;
    sendRsp(32'h7777_0001, 1'b0, 4'h4);
    settle();
    cmdRingEmpty = 1'b0;
    chk("R7 empty irq", 32'(rspIntSts), 32'd1);
    chk("R2 after reset addr", beatAddr[16], BASE + 32'd8);
    r0 = retrigCnt;
    cfgWrite(3'd4, 32'd0);
    repeat (2) @(negedge clk);
    chk("R9 zero write", 32'(rspIntSts), 32'd1);
    chk("R9 no pulse", 32'(retrigCnt), 32'(r0));
    cfgWrite(3'd4, 32'd1);
    repeat (2) @(negedge clk);
    chk("R9 clear", 32'(rspIntSts), 32'd0);
    chk("R9 pulse", 32'(retrigCnt), 32'(r0 + 1));

    // R5 R12 immediate path
    cfgWrite(3'd5, 32'd1);
    chk("R12 busy set", 32'(immBusy), 32'd1);
    sendRsp(32'hCAFE_0009, 1'b1, 4'h9);
    settle();
    chk("R5 resp", immResp, 32'hCAFE_0009);
    chk("R5 valid", 32'(immValid), 32'd1);
    chk("R5 busy clr", 32'(immBusy), 32'd0);
    chk("R5 codec", 32'(immCodec), 32'd9);
    chk("R5 wp kept", 32'(ringWp), 32'd1);
    chk("R5 no beat", 32'(beatCnt), 32'd18);
    cfgWrite(3'd5, 32'd2);
    chk("R12 valid clr", 32'(immValid), 32'd0);

    // R11 backpressure
    @(negedge clk);
    memWrAck = 1'b0;
    sendRsp(32'h0BAD_0001, 1'b0, 4'h5);
    @(negedge clk);
    rspValid = 1'b1; rspData = 32'h0BAD_0002; rspUnsol = 1'b1; rspCodec = 4'h6;
    repeat (4) @(negedge clk);
    chk("R11 ready low", 32'(rspReady), 32'd0);
    chk("R11 beat pending", 32'(memWrValid), 32'd1);
    chk("R11 stalled addr", memWrAddr, BASE + 32'd16);
    chk("R11 no beat", 32'(beatCnt), 32'd18);
    memWrAck = 1'b1;
    while (!rspReady) @(negedge clk);
    @(negedge clk);
    rspValid = 1'b0;
    settle();
    chk("R11 beat cnt", 32'(beatCnt), 32'd22);
    chk("R11 first data", beatData[18], 32'h0BAD_0001);
    chk("R11 second data", beatData[20], 32'h0BAD_0002);
    chk("R11 second ext", beatData[21], 32'h0000_0016);
    chk("R11 second addr", beatAddr[20], BASE + 32'd24);
    chk("R11 wp", 32'(ringWp), 32'd3);

    // R2 wrap and R8 interrupt disabled
    cfgWrite(3'd3, 32'd1);
    cfgWrite(3'd1, 32'h0000_8000);
    for (int k = 0; k < 255; k++) sendRsp(32'(k), 1'b0, 4'h2);
    settle();
    chk("R2 wp 255", 32'(ringWp), 32'd255);
    chk("R8 no irq", 32'(rspIntSts), 32'd0);
    sendRsp(32'h600D_F00D, 1'b0, 4'h2);
    settle();
    chk("R2 wrap wp", 32'(ringWp), 32'd0);
    chk("R2 wrap addr", beatAddr[532], BASE);
    chk("R2 wrap data", beatData[532], 32'h600D_F00D);
    chk("R8 still no irq", 32'(rspIntSts), 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule